// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

The decoder takes a stream of 16-bit instruction halfwords over a valid/ready handshake. It works out whether each instruction is one halfword long or three halfwords long. For every instruction it emits one decoded record. The record carries:

- the instruction class
- a form flag (register, short memory reference, indexed extended reference, or other extended reference)
- the operation and the data type
- the destination and source register numbers
- the base, index and displacement fields
- an illegal-encoding flag

Two decode flavours are supported, selected by `semi_mode`.

- **Standard flavour (`semi_mode` = 0).** Memory instructions carry a 5-bit opcode.
- **Restricted load/store flavour (`semi_mode` = 1).** Memory instructions carry a 4-bit load/store opcode, and scratchpad instructions may only target primary registers 0 to 3.

The flavour is taken together with the first halfword of each instruction. The extension halfwords never change it.

Sequencing is done by a three-state machine.

- **S_IDLE** waits for a first halfword.
  - A first halfword that is complete on its own produces a record and the machine stays in S_IDLE.
  - A memory or operate halfword whose base field is zero moves the machine to S_EXT1.
- **S_EXT1** accepts the first extension halfword and moves to S_EXT2.
- **S_EXT2** accepts the second extension halfword, produces the extended record and returns to S_IDLE.

A synchronous reset returns the machine to S_IDLE and drops any partly assembled instruction.

Top module: `altdec_top`

## Requirements
- R1: While `rst` is high at a clock edge, the machine enters S_IDLE and `out_valid` clears; `in_ready` is high after reset. A partly assembled instruction is discarded, so the next halfword accepted after reset is decoded as a first halfword.
- R2: First-halfword layout: bits [15:14] are the class, with 0 = register, 1 = memory, 2 = scratchpad and 3 = operate; `out_cls` carries this value. Bits [13:9] are the opcode, [8:6] field A, [5:3] field B and [2:0] field C. A register instruction reports dst = A and src = B.
- R3: A single-halfword instruction produces a record with `out_valid` high in the cycle after the halfword is accepted. Register and scratchpad instructions report form 0 (register). Memory and operate instructions with a nonzero base field report form 1 (short). A short memory instruction reports dst = A, disp = B and base = C.
- R4: A memory or operate instruction whose field C is zero needs two more halfwords and produces no record until the third halfword is accepted; the record is valid in the following cycle. For register instructions, field C has no such effect.
- R5: When bit 15 of the first extension halfword is 0, the form is 2 (indexed extended). The index is ext1[14:12], where 0 means no indexing. The scratchpad pointer base is ext1[11:9]. The 25-bit displacement is {ext1[8:0], ext2[15:0]}.
- R6: When bit 15 of the first extension halfword is 1, the form is 3 (other extended), and index, base and displacement all read 0.
- R7: In standard decode, the opcode's top two bits give the type: 00 gives word (type 2), 10 gives float (type 5) and 11 gives double (type 6). The low three bits give swap, compare, load, store, add, subtract, multiply and divide, numbered 0 to 7.
- R8: Opcode group 01 is word type. Its low-bit codes are 001 unsigned compare (8), 011 xor (9), 100 and (10), 101 or (11), 110 multiply-extended (12) and 111 divide-extended (13). Codes 01000 and 01010 set `out_illegal` and report operation 15 with type 2.
- R9: A scratchpad instruction reports dst = bits [8:6] and a 6-bit src = bits [5:0].
- R10: In restricted mode, a scratchpad instruction with dst 4 to 7 is flagged illegal; dst 0 to 3 is legal. In standard mode all eight destinations are legal.
- R11: In restricted mode, a memory instruction uses opcode bits [13:10]. Bit 10 even means load (2) and odd means store (3). Bits [13:11] give the type: 0 byte, 1 half, 2 word, 3 long, 4 medium, 5 float, 6 double, 7 quad. Bit 9 set is illegal. The mode is sampled with the first halfword only.
- R12: An operate instruction reports operation 15, type 2, dst = B, index = A and base = C. With C = 0 it is extended, and a nonzero A is flagged illegal.
- R13: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. During such a stall the record outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| semi_mode | input | 1 | 1 selects restricted load/store decode |
| in_valid | input | 1 | Halfword offered |
| in_hw | input | 16 | Instruction halfword |
| in_ready | output | 1 | Halfword can be taken |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Record consumer ready |
| out_cls | output | 2 | Instruction class |
| out_form | output | 2 | Form: register, short, indexed extended, other extended |
| out_op | output | 4 | Decoded operation |
| out_dtype | output | 3 | Data type |
| out_dst | output | 3 | Destination register |
| out_src | output | 6 | Source register |
| out_base | output | 3 | Base or scratchpad pointer register |
| out_index | output | 3 | Index register, 0 = none |
| out_disp | output | 25 | Displacement |
| out_illegal | output | 1 | Illegal encoding |

## Verification
Every record is due one cycle after its last halfword is accepted. For a single-halfword instruction that halfword is the first; for an extended one it is the third. The bench samples `out_valid` at the falling edge that follows the accepting rising edge. A scoreboard compares each record, in order, at the falling edge before it is transferred, and a record with no matching expectation counts as a failure. During stalls the bench checks, at every falling edge, that the record held its value and that `in_ready` tracked the stall.

// File: rtl/altdec_pkg.sv
package altdec_pkg;
    localparam int HW_W   = 16;
    localparam int FLD_W  = 3;
    localparam int OP_W   = 5;
    localparam int SRC_W  = 2 * FLD_W;
    localparam int DISP_W = 2 * HW_W - 1 - 2 * FLD_W;

    typedef enum logic [1:0] {
        CLS_RR   = 2'd0,
        CLS_MEM  = 2'd1,
        CLS_SPAD = 2'd2,
        CLS_OPER = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        FORM_REG     = 2'd0,
        FORM_SHORT   = 2'd1,
        FORM_IDX_EXT = 2'd2,
        FORM_OTH_EXT = 2'd3
    } form_e;

    typedef enum logic [3:0] {
        OP_SWAP  = 4'd0,
        OP_CMP   = 4'd1,
        OP_LOAD  = 4'd2,
        OP_STORE = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_MUL   = 4'd6,
        OP_DIV   = 4'd7,
        OP_UCMP  = 4'd8,
        OP_XOR   = 4'd9,
        OP_AND   = 4'd10,
        OP_OR    = 4'd11,
        OP_MULX  = 4'd12,
        OP_DIVX  = 4'd13,
        OP_NONE  = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        DT_BYTE   = 3'd0,
        DT_HALF   = 3'd1,
        DT_WORD   = 3'd2,
        DT_LONG   = 3'd3,
        DT_MEDIUM = 3'd4,
        DT_FLOAT  = 3'd5,
        DT_DOUBLE = 3'd6,
        DT_QUAD   = 3'd7
    } dtype_e;

    typedef struct packed {
        cls_e                cls;
        form_e               form;
        op_e                 op;
        dtype_e              dtype;
        logic [FLD_W-1:0]    dst;
        logic [SRC_W-1:0]    src;
        logic [FLD_W-1:0]    base;
        logic [FLD_W-1:0]    index;
        logic [DISP_W-1:0]   disp;
        logic                illegal;
    } dec_rec_t;
endpackage

// File: rtl/altdec_opcode.sv
module altdec_opcode
    import altdec_pkg::*;
(
    input  logic [OP_W-1:0] code,
    input  logic            ls4,
    output op_e             op,
    output dtype_e          dtype,
    output logic            bad
);
    localparam int GRP_W = 2;
    localparam int LOW_W = OP_W - GRP_W;

    always_comb begin
        op    = OP_NONE;
        dtype = DT_WORD;
        bad   = 1'b0;
        if (ls4) begin
            // 4-bit load/store code lives in the upper bits, lowest bit reserved
            op    = code[1] ? OP_STORE : OP_LOAD;
            dtype = dtype_e'(code[OP_W-1 -: 3]);
            bad   = code[0];
        end else begin
            unique case (code[OP_W-1 -: GRP_W])
                2'b00: begin
                    dtype = DT_WORD;
                    op    = op_e'({1'b0, code[LOW_W-1:0]});
                end
                2'b01: begin
                    dtype = DT_WORD;
                    unique case (code[LOW_W-1:0])
                        3'd1:    op = OP_UCMP;
                        3'd3:    op = OP_XOR;
                        3'd4:    op = OP_AND;
                        3'd5:    op = OP_OR;
                        3'd6:    op = OP_MULX;
                        3'd7:    op = OP_DIVX;
                        default: bad = 1'b1;
                    endcase
                end
                2'b10: begin
                    dtype = DT_FLOAT;
                    op    = op_e'({1'b0, code[LOW_W-1:0]});
                end
                default: begin
                    dtype = DT_DOUBLE;
                    op    = op_e'({1'b0, code[LOW_W-1:0]});
                end
            endcase
        end
    end
endmodule

// File: rtl/altdec_head.sv
module altdec_head
    import altdec_pkg::*;
#(
    parameter int PFX_LSB = 14,
    parameter int OP_LSB  = 9,
    parameter int FA_LSB  = 6,
    parameter int FB_LSB  = 3,
    parameter int FC_LSB  = 0
) (
    input  logic [HW_W-1:0] hw,
    input  logic            semi,
    output dec_rec_t        rec,
    output logic            needs_ext
);
    logic [1:0]       pfx;
    logic [OP_W-1:0]  code;
    logic [FLD_W-1:0] fa, fb, fc;
    logic [SRC_W-1:0] src_wide;
    logic             ls4;
    op_e              dec_op;
    dtype_e           dec_dt;
    logic             dec_bad;

    assign pfx      = hw[PFX_LSB +: 2];
    assign code     = hw[OP_LSB +: OP_W];
    assign fa       = hw[FA_LSB +: FLD_W];
    assign fb       = hw[FB_LSB +: FLD_W];
    assign fc       = hw[FC_LSB +: FLD_W];
    assign src_wide = hw[FC_LSB +: SRC_W];
    assign ls4      = semi && (pfx == CLS_MEM);

    altdec_opcode u_opcode (
        .code  (code),
        .ls4   (ls4),
        .op    (dec_op),
        .dtype (dec_dt),
        .bad   (dec_bad)
    );

    always_comb begin
        rec         = '0;
        rec.cls     = cls_e'(pfx);
        rec.form    = FORM_REG;
        rec.op      = dec_op;
        rec.dtype   = dec_dt;
        rec.illegal = dec_bad;
        needs_ext   = 1'b0;
        unique case (pfx)
            2'd0: begin
                rec.dst = fa;
                rec.src = {{FLD_W{1'b0}}, fb};
            end
            2'd1: begin
                rec.form  = FORM_SHORT;
                rec.dst   = fa;
                rec.disp  = DISP_W'(fb);
                rec.base  = fc;
                needs_ext = (fc == '0);
            end
            2'd2: begin
                rec.dst = fa;
                rec.src = src_wide;
                if (semi && fa[FLD_W-1]) rec.illegal = 1'b1;
            end
            default: begin
                rec.form    = FORM_SHORT;
                rec.op      = OP_NONE;
                rec.dtype   = DT_WORD;
                rec.dst     = fb;
                rec.index   = fa;
                rec.base    = fc;
                needs_ext   = (fc == '0);
                rec.illegal = (fc == '0) && (fa != '0);
            end
        endcase
    end
endmodule

// File: rtl/altdec_top.sv
module altdec_top
    import altdec_pkg::*;
#(
    parameter int PFX_LSB = 14,
    parameter int OP_LSB  = 9,
    parameter int FA_LSB  = 6,
    parameter int FB_LSB  = 3,
    parameter int FC_LSB  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              semi_mode,
    input  logic              in_valid,
    input  logic [HW_W-1:0]   in_hw,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_cls,
    output logic [1:0]        out_form,
    output logic [3:0]        out_op,
    output logic [2:0]        out_dtype,
    output logic [FLD_W-1:0]  out_dst,
    output logic [SRC_W-1:0]  out_src,
    output logic [FLD_W-1:0]  out_base,
    output logic [FLD_W-1:0]  out_index,
    output logic [DISP_W-1:0] out_disp,
    output logic              out_illegal
);
    localparam int EXT_TAG = HW_W - 1;
    localparam int XI_LSB  = EXT_TAG - FLD_W;
    localparam int XB_LSB  = XI_LSB - FLD_W;
    localparam int XD_HI_W = XB_LSB;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXT1 = 2'd1,
        S_EXT2 = 2'd2
    } state_e;

    state_e            state_q, state_d;
    dec_rec_t          head_c, head_q, ext_c, rec_q;
    logic              needs_ext;
    logic [HW_W-1:0]   ext1_q;
    logic              in_fire, emit_short, emit_ext;

    altdec_head #(
        .PFX_LSB (PFX_LSB),
        .OP_LSB  (OP_LSB),
        .FA_LSB  (FA_LSB),
        .FB_LSB  (FB_LSB),
        .FC_LSB  (FC_LSB)
    ) u_head (
        .hw        (in_hw),
        .semi      (semi_mode),
        .rec       (head_c),
        .needs_ext (needs_ext)
    );

    assign in_ready   = !out_valid || out_ready;
    assign in_fire    = in_valid && in_ready;
    assign emit_short = (state_q == S_IDLE) && in_fire && !needs_ext;
    assign emit_ext   = (state_q == S_EXT2) && in_fire;

    // Merge the stored head with the two extension halfwords
    always_comb begin
        ext_c = head_q;
        if (ext1_q[EXT_TAG]) begin
            ext_c.form  = FORM_OTH_EXT;
            ext_c.index = '0;
            ext_c.base  = '0;
            ext_c.disp  = '0;
        end else begin
            ext_c.form  = FORM_IDX_EXT;
            ext_c.index = ext1_q[XI_LSB +: FLD_W];
            ext_c.base  = ext1_q[XB_LSB +: FLD_W];
            ext_c.disp  = {ext1_q[XD_HI_W-1:0], in_hw};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_fire && needs_ext) state_d = S_EXT1;
            S_EXT1:  if (in_fire) state_d = S_EXT2;
            S_EXT2:  if (in_fire) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            rec_q     <= '0;
            head_q    <= '0;
            ext1_q    <= '0;
        end else begin
            if (state_q == S_IDLE && in_fire && needs_ext) head_q <= head_c;
            if (state_q == S_EXT1 && in_fire) ext1_q <= in_hw;
            if (emit_short) begin
                rec_q     <= head_c;
                out_valid <= 1'b1;
            end else if (emit_ext) begin
                rec_q     <= ext_c;
                out_valid <= 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign out_cls     = rec_q.cls;
    assign out_form    = rec_q.form;
    assign out_op      = rec_q.op;
    assign out_dtype   = rec_q.dtype;
    assign out_dst     = rec_q.dst;
    assign out_src     = rec_q.src;
    assign out_base    = rec_q.base;
    assign out_index   = rec_q.index;
    assign out_disp    = rec_q.disp;
    assign out_illegal = rec_q.illegal;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && state_q == S_IDLE));

    assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(rec_q)));

    assert_ext_emit_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EXT2 && in_fire) |=>
            (out_valid && (out_form == FORM_IDX_EXT || out_form == FORM_OTH_EXT)));

    assert_ext_order_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EXT2) |-> ($past(state_q) != S_IDLE));

    assert_other_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_form == FORM_OTH_EXT) |->
            (out_index == '0 && out_base == '0 && out_disp == '0));
endmodule

// File: tb/altdec_top_tb.sv
module altdec_top_tb;
    import altdec_pkg::*;

    typedef logic [51:0] exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        semi_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_hw = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_cls, out_form;
    logic [3:0]  out_op;
    logic [2:0]  out_dtype, out_dst, out_base, out_index;
    logic [5:0]  out_src;
    logic [24:0] out_disp;
    logic        out_illegal;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   bp = 1'b0;
    bit   held = 1'b0;
    exp_t held_val;
    exp_t exp_q[$];
    string tag_q[$];
    exp_t act;

    always #4 clk = ~clk;

    altdec_top u_dut (
        .clk(clk), .rst(rst), .semi_mode(semi_mode),
        .in_valid(in_valid), .in_hw(in_hw), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_cls(out_cls), .out_form(out_form), .out_op(out_op),
        .out_dtype(out_dtype), .out_dst(out_dst), .out_src(out_src),
        .out_base(out_base), .out_index(out_index), .out_disp(out_disp),
        .out_illegal(out_illegal)
    );

    assign act = {out_cls, out_form, out_op, out_dtype, out_dst, out_src,
                  out_base, out_index, out_disp, out_illegal};

    function automatic exp_t pk(int cls, int form, int op, int dt, int dst, int src,
                                int base, int idx, int disp, int ill);
        return {cls[1:0], form[1:0], op[3:0], dt[2:0], dst[2:0], src[5:0],
                base[2:0], idx[2:0], disp[24:0], ill[0]};
    endfunction

    function automatic logic [15:0] hw(int p, int op, int a, int b, int c);
        return {p[1:0], op[4:0], a[2:0], b[2:0], c[2:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, a, e);
        end
    endtask

    task automatic expect_rec(input string tag, input exp_t e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [15:0] h);
        @(negedge clk);
        in_valid = 1'b1;
        in_hw    = h;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic due_now(input string tag);
        @(negedge clk);
        chk(tag, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
    endtask

    always @(posedge clk) begin
        cyc++;
        #2 out_ready = bp ? (cyc % 3 == 0) : 1'b1;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            held = 1'b0;
        end else begin
            chk("R13 in_ready", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
            if (held) chk("R13 held record", {12'd0, act}, {12'd0, held_val});
            held     = out_valid && !out_ready;
            held_val = act;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R3 unexpected record actual %h expected none", act);
                end else begin
                    chk(tag_q.pop_front(), {12'd0, act}, {12'd0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // Standard decode, single halfword
        expect_rec("R2 R7 register add", pk(0,0,4,2,3,5,0,0,0,0));
        send(hw(0,'b00100,3,5,7));
        due_now("R3 single halfword due");
        expect_rec("R7 R4 float divide, C=0 ignored", pk(0,0,7,5,1,2,0,0,0,0));
        send(hw(0,'b10111,1,2,0));
        expect_rec("R7 double load", pk(0,0,2,6,0,7,0,0,0,0));
        send(hw(0,'b11010,0,7,1));
        expect_rec("R8 ucmp", pk(0,0,8,2,1,1,0,0,0,0));
        send(hw(0,'b01001,1,1,1));
        expect_rec("R8 xor", pk(0,0,9,2,2,4,0,0,0,0));
        send(hw(0,'b01011,2,4,1));
        expect_rec("R8 divx", pk(0,0,13,2,0,0,0,0,0,0));
        send(hw(0,'b01111,0,0,2));
        expect_rec("R8 01000 illegal", pk(0,0,15,2,5,6,0,0,0,1));
        send(hw(0,'b01000,5,6,3));
        expect_rec("R8 01010 illegal", pk(0,0,15,2,1,2,0,0,0,1));
        send(hw(0,'b01010,1,2,3));
        expect_rec("R9 R10 scratchpad std dst6", pk(2,0,2,5,6,45,0,0,0,0));
        send({2'b10, 5'b10010, 3'd6, 6'd45});
        expect_rec("R3 short memory", pk(1,1,3,2,2,0,4,0,5,0));
        send(hw(1,'b00011,2,5,4));
        due_now("R3 short memory due");
        expect_rec("R12 operate short", pk(3,1,15,2,4,0,6,3,0,0));
        send(hw(3,'b00000,3,4,6));
        drain();

        // Extended forms
        expect_rec("R4 R5 indexed ext", pk(1,2,2,2,7,0,2,5,'h1A5BEEF,0));
        send(hw(1,'b00010,7,3,0));
        send(16'h55A5);
        send(16'hBEEF);
        due_now("R4 ext due after third");
        expect_rec("R5 no index", pk(1,2,3,5,4,0,6,0,7,0));
        send(hw(1,'b10011,4,0,0));
        send(16'h0C00);
        send(16'h0007);
        expect_rec("R6 other ext", pk(1,3,4,2,1,0,0,0,0,0));
        send(hw(1,'b00100,1,0,0));
        send(16'h8123);
        send(16'h4567);
        expect_rec("R12 operate ext illegal", pk(3,2,15,2,1,0,0,1,1,1));
        send(hw(3,'b00101,2,1,0));
        send(16'h1000);
        send(16'h0001);
        expect_rec("R12 operate ext legal", pk(3,2,15,2,5,0,7,0,0,0));
        send(hw(3,'b00000,0,5,0));
        send(16'h0E00);
        send(16'h0000);
        drain();

        // Restricted decode
        semi_mode = 1'b1;
        expect_rec("R10 scratchpad dst3 ok", pk(2,0,4,2,3,63,0,0,0,0));
        send({2'b10, 5'b00100, 3'd3, 6'd63});
        expect_rec("R10 scratchpad dst4 illegal", pk(2,0,4,2,4,1,0,0,0,1));
        send({2'b10, 5'b00100, 3'd4, 6'd1});
        expect_rec("R11 store double", pk(1,1,3,6,2,0,3,0,1,0));
        send(hw(1,'b11010,2,1,3));
        expect_rec("R11 load byte", pk(1,1,2,0,0,0,5,0,0,0));
        send(hw(1,'b00000,0,0,5));
        expect_rec("R11 bit9 illegal", pk(1,1,2,2,1,0,2,0,0,1));
        send(hw(1,'b01001,1,0,2));
        expect_rec("R11 mode sampled at head", pk(1,2,3,1,6,0,1,2,16,0));
        send(hw(1,'b00110,6,0,0));
        semi_mode = 1'b0;
        send(16'h2200);
        send(16'h0010);
        drain();

        // Back-pressure
        bp = 1'b1;
        expect_rec("R13 stalled add", pk(0,0,4,2,3,5,0,0,0,0));
        send(hw(0,'b00100,3,5,7));
        expect_rec("R13 stalled short mem", pk(1,1,3,2,2,0,4,0,5,0));
        send(hw(1,'b00011,2,5,4));
        expect_rec("R13 stalled ext", pk(1,2,2,2,7,0,2,5,'h1A5BEEF,0));
        send(hw(1,'b00010,7,3,0));
        send(16'h55A5);
        send(16'hBEEF);
        expect_rec("R13 stalled operate", pk(3,1,15,2,4,0,6,3,0,0));
        send(hw(3,'b00000,3,4,6));
        drain();
        bp = 1'b0;

        // Reset drops partial instruction
        send(hw(1,'b00010,7,3,0));
        do_reset();
        expect_rec("R1 head after reset", pk(0,0,5,2,2,3,0,0,0,0));
        send(hw(0,'b00101,2,3,0));
        due_now("R1 decoded alone");
        drain();

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule